// File: doc/BRIEF.md
# Cascaded Up/Down Coefficient Counter

This block turns a stream of single-step adaptation commands (one step up or one step down) into a slowly moving coefficient code for an adaptive equalizer tap. It has two counters in series. A small signed pre-counter takes in every step. The wider main counter, whose value is the coefficient code, moves only when the pre-counter reaches a full-scale bound.

When an up step would bring the pre-counter to its positive bound, the pre-counter returns to zero and raises a one-cycle carry pulse. A down step that reaches the negative bound does the same with a borrow pulse. A carry increments the main code and a borrow decrements it, and the code clips at its end codes rather than wrapping. Once adaptation has settled, the steps mostly cancel in the pre-counter, so the code stays still. The carry and borrow pulses are brought out so they can gate a charge pump directly.

The asynchronous reset input is synchronised inside the block before it releases the registers.

Top module: `coef_cascade_counter`

## Requirements
- R1: While reset is active, and once it has been released, carry and borrow are low and the code equals the parameter INIT_CODE (default 32); the pre-counter starts from zero.
- R2: The pre-counter is signed, with positive bound 2**(PRE_W-1)-1 (7 by default). An up step taken when the pre-counter holds bound-1 (+6) clears it to zero and raises carry for exactly one cycle, so seven up steps from zero give one carry.
- R3: A down step taken when the pre-counter holds -(bound-1) (-6) clears it to zero and raises borrow for exactly one cycle.
- R4: A carry raises the code by one. The new code appears on the same clock edge that raises carry.
- R5: A borrow lowers the code by one. The new code appears on the same clock edge that raises borrow.
- R6: With no carry and no borrow the code holds. While the strobe upd_valid is low, the direction input upd_up has no effect on any output.
- R7: The code saturates: a carry at code 2**MAIN_W-1 (63) and a borrow at code 0 leave it unchanged, but the pulse is still emitted.
- R8: Carry and borrow are never high in the same cycle, and two pulses are separated by at least 2**(PRE_W-1)-1 (7) accepted steps.
- R9: Up and down steps accumulate as a signed net count in the pre-counter, so a balanced alternating pattern produces no pulse and no code change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| upd_valid | input | 1 | Strobe: one adaptation step this cycle |
| upd_up | input | 1 | Step direction: 1 = up, 0 = down |
| coef_code | output | MAIN_W | Coefficient code from the main counter |
| carry_pulse | output | 1 | One-cycle pulse when the pre-counter overflows |
| borrow_pulse | output | 1 | One-cycle pulse when the pre-counter underflows |

## Verification
The pre-counter cannot be seen at the ports. A wrong value in it shows up only as a carry or borrow that comes too early or too late, so it can hide for up to six steps. It is exposed at the next bound crossing, where the pulse position and the code step are both checked against a behavioural model on every cycle. A fault in the main counter shows at once on the code in the cycle of the pulse. The saturation runs and a long pseudo-random step stream reach the end codes and mixed orderings that directed patterns miss.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/ccc_rst_sync.sv
module ccc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ccc_pre_counter.sv
module ccc_pre_counter
  import ccc_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_valid,
  input  logic step_up,
  output logic wrap_up,
  output logic wrap_down,
  output logic carry_q,
  output logic borrow_q
);
  localparam int BOUND = (2 ** (PRE_W - 1)) - 1;

  logic signed [PRE_W-1:0] pre_q, pre_d;
  logic                    carry_d, borrow_d;
  step_e                   step;

  always_comb begin
    if (!step_valid)  step = STEP_NONE;
    else if (step_up) step = STEP_UP;
    else              step = STEP_DOWN;
  end

  always_comb begin
    wrap_up   = 1'b0;
    wrap_down = 1'b0;
    pre_d     = pre_q;
    case (step)
      STEP_UP: begin
        if (pre_q == PRE_W'(BOUND - 1)) begin
          wrap_up = 1'b1;
          pre_d   = '0;
        end else begin
          pre_d = pre_q + PRE_W'(1);
        end
      end
      STEP_DOWN: begin
        if (pre_q == -PRE_W'(BOUND - 1)) begin
          wrap_down = 1'b1;
          pre_d     = '0;
        end else begin
          pre_d = pre_q - PRE_W'(1);
        end
      end
      default: pre_d = pre_q;
    endcase
    carry_d  = wrap_up;
    borrow_d = wrap_down;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      if (step_valid) pre_q <= pre_d;
      carry_q  <= carry_d;
      borrow_q <= borrow_d;
    end
  end

  // Checker state: accepted steps since the last pulse, saturating at BOUND.
  logic [PRE_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (carry_q || borrow_q) gap_q <= PRE_W'(step_valid);
    else if (step_valid && gap_q != PRE_W'(BOUND)) gap_q <= gap_q + PRE_W'(1);
  end

  assert_pre_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q < PRE_W'(BOUND)) && (pre_q > -PRE_W'(BOUND)));

  assert_carry_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    carry_q |=> !carry_q);

  assert_borrow_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_q |=> !borrow_q);

  assert_no_dual_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_q && borrow_q));

  assert_pulse_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_up || wrap_down) |-> (gap_q >= PRE_W'(BOUND - 1)));

  assert_pre_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_up || wrap_down) |=> (pre_q == '0));
endmodule

// File: rtl/ccc_main_counter.sv
module ccc_main_counter #(
  parameter int MAIN_W    = 6,
  parameter int INIT_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [MAIN_W-1:0] code_q
);
  localparam logic [MAIN_W-1:0] CODE_MAX  = {MAIN_W{1'b1}};
  localparam logic [MAIN_W-1:0] CODE_MIN  = '0;
  localparam logic [MAIN_W-1:0] CODE_INIT = MAIN_W'(INIT_CODE);

  logic [MAIN_W-1:0] code_d;
  logic              code_en;

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    if (inc && code_q != CODE_MAX) begin
      code_en = 1'b1;
      code_d  = code_q + MAIN_W'(1);
    end else if (dec && code_q != CODE_MIN) begin
      code_en = 1'b1;
      code_d  = code_q - MAIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CODE_INIT;
    else if (code_en) code_q <= code_d;
  end

  assert_inc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && code_q != CODE_MAX) |=> (code_q == MAIN_W'($past(code_q) + 1'b1)));

  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && code_q != CODE_MIN) |=> (code_q == MAIN_W'($past(code_q) - 1'b1)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(code_q));

  assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && code_q == CODE_MAX) |=> (code_q == CODE_MAX));

  assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && code_q == CODE_MIN) |=> (code_q == CODE_MIN));
endmodule

// File: rtl/coef_cascade_counter.sv
module coef_cascade_counter #(
  parameter int PRE_W     = 4,
  parameter int MAIN_W    = 6,
  parameter int INIT_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic              upd_up,
  output logic [MAIN_W-1:0] coef_code,
  output logic              carry_pulse,
  output logic              borrow_pulse
);
  logic rst_n_int;
  logic wrap_up, wrap_down;

  ccc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ccc_pre_counter #(.PRE_W(PRE_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .step_valid (upd_valid),
    .step_up    (upd_up),
    .wrap_up    (wrap_up),
    .wrap_down  (wrap_down),
    .carry_q    (carry_pulse),
    .borrow_q   (borrow_pulse)
  );

  ccc_main_counter #(.MAIN_W(MAIN_W), .INIT_CODE(INIT_CODE)) u_main (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .inc    (wrap_up),
    .dec    (wrap_down),
    .code_q (coef_code)
  );

  assert_reset_code_R1: assert property (@(posedge clk)
    !rst_n_int |=> (!carry_pulse && !borrow_pulse));
endmodule

// File: tb/coef_cascade_counter_tb.sv
module coef_cascade_counter_tb;
  localparam int PRE_W     = 4;
  localparam int MAIN_W    = 6;
  localparam int INIT_CODE = 32;
  localparam int BOUND     = (2 ** (PRE_W - 1)) - 1;
  localparam int CMAX      = (2 ** MAIN_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              upd_valid;
  logic              upd_up;
  logic [MAIN_W-1:0] coef_code;
  logic              carry_pulse, borrow_pulse;

  int vectors = 0;
  int errors  = 0;
  int m_pre, m_code, m_gap;
  bit m_carry, m_borrow;
  string cur_req;
  logic [15:0] lfsr;

  always #2.5 clk = ~clk;

  coef_cascade_counter #(.PRE_W(PRE_W), .MAIN_W(MAIN_W), .INIT_CODE(INIT_CODE)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_valid    (upd_valid),
    .upd_up       (upd_up),
    .coef_code    (coef_code),
    .carry_pulse  (carry_pulse),
    .borrow_pulse (borrow_pulse)
  );

  task automatic compare();
    vectors++;
    if (int'(coef_code) != m_code || carry_pulse != m_carry || borrow_pulse != m_borrow) begin
      errors++;
      $display("FAIL %s: code=%0d carry=%0b borrow=%0b expected code=%0d carry=%0b borrow=%0b",
               cur_req, coef_code, carry_pulse, borrow_pulse, m_code, m_carry, m_borrow);
    end
    if (carry_pulse && borrow_pulse) begin
      errors++;
      $display("FAIL R8: carry=1 borrow=1 expected at most one high");
    end
  endtask

  task automatic model(input bit v, input bit u);
    m_carry  = 1'b0;
    m_borrow = 1'b0;
    if (v) begin
      m_gap++;
      if (u) begin
        if (m_pre + 1 == BOUND) begin
          m_pre = 0; m_carry = 1'b1;
          if (m_code < CMAX) m_code++;
        end else m_pre++;
      end else begin
        if (m_pre - 1 == -BOUND) begin
          m_pre = 0; m_borrow = 1'b1;
          if (m_code > 0) m_code--;
        end else m_pre--;
      end
      if (m_carry || m_borrow) begin
        // R8: pulses separated by at least BOUND accepted steps
        vectors++;
        if (m_gap < BOUND) begin
          errors++;
          $display("FAIL R8: gap=%0d expected >= %0d", m_gap, BOUND);
        end
        m_gap = 0;
      end
    end
  endtask

  task automatic cyc(input bit v, input bit u);
    @(negedge clk);
    compare();
    upd_valid = v;
    upd_up    = u;
    model(v, u);
  endtask

  task automatic run(input bit v, input bit u, input int n);
    for (int i = 0; i < n; i++) cyc(v, u);
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_valid = 1'b0; upd_up = 1'b0;
    m_pre = 0; m_code = INIT_CODE; m_gap = BOUND; m_carry = 0; m_borrow = 0;
    cur_req = "R1";
    // R1: outputs during reset
    for (int i = 0; i < 4; i++) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    run(1'b0, 1'b0, 5);                 // R1 after release
    cur_req = "R2"; run(1'b1, 1'b1, 6); // no pulse yet
    cur_req = "R4"; run(1'b1, 1'b1, 1); // carry, code 33
    run(1'b0, 1'b0, 2);
    cur_req = "R6";                     // strobe low, direction toggling
    for (int i = 0; i < 12; i++) cyc(1'b0, i[0]);
    cur_req = "R3"; run(1'b1, 1'b0, 7); // borrow, code 32
    cur_req = "R5"; run(1'b1, 1'b0, 14);
    run(1'b0, 1'b0, 2);
    cur_req = "R9";
    for (int i = 0; i < 40; i++) cyc(1'b1, i[0]);
    run(1'b1, 1'b1, 3);
    run(1'b1, 1'b0, 6);                 // net -3 accumulates
    cur_req = "R7"; run(1'b1, 1'b1, BOUND * 45);
    run(1'b1, 1'b0, BOUND * 75);
    cur_req = "R8";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[3], lfsr[5] | (lfsr[7] & lfsr[2]));
    end
    run(1'b0, 1'b0, 3);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule